// File: doc/BRIEF.md
# Serial Poll Capture Unit

This block is the device-side half of a serially chained service arbitration scheme. A device that wants an interrupt or a cycle-steal transfer raises one line of a 16-line request bus, chosen by decoding its assigned 4-bit level. The channel answers by presenting a poll identifier and then raising a poll tag. That tag travels from device to device along a chain. Each device either keeps the poll, answering with a return tag and then taking the service gate, or hands it to the next device on a propagate output. Devices closer to the channel see the poll first and so win over devices further along the chain.

The keep-or-pass choice is made in a decision register that tracks the poll identifier while the tag is low and freezes when the tag rises. A capture for an interrupt or a single cycle steal is answered with the plain return tag. A capture for a burst cycle steal is answered with the burst return tag. The capture is held until the transfer logic reports that service-gate return has been seen. At that point the request line is dropped, unless the device core signals that another transfer is pending. A prime input must be high for any capture to happen. Any channel reset (system reset, power-on reset, halt or machine check) clears the whole unit.

Top module: `poll_capture_unit`

## Requirements
- R1: While an interrupt or cycle-steal request is pending, `req_bus` has exactly bit `dev_level` set. With nothing pending it is all zero. The bus follows the request latches one cycle later.
- R2: The poll identifier uses bit 4 as the kind (1 = cycle steal, 0 = interrupt) and bits 3:0 as the level. A poll matches only if its level equals `dev_level` and a request of its kind is pending.
- R3: One cycle after `poll_tag` is first sampled high, exactly one of `poll_return`, `burst_return` or `poll_propagate` is high. It stays high while the tag stays high and is low one cycle after the tag is sampled low.
- R4: A capture of an interrupt poll, or of a cycle-steal poll whose request was made without burst, drives `poll_return`. A capture of a cycle-steal poll whose request was made with `burst_req` high drives `burst_return`.
- R5: The decision is taken from the inputs sampled before the tag rises. Inputs that change while the tag is high do not change the answer.
- R6: A request whose bus line was not yet driven in the cycle before the tag rise is a lagging request, and the poll is propagated.
- R7: While `poll_prime` is low, every poll is propagated.
- R8: `captured` goes high with the return tag and stays high after the tag falls. `svc_capture` is set one cycle after `svc_gate` is seen while captured. `gate_ret_seen` while `svc_capture` is high clears both on the next edge. The served request line then drops one cycle later, unless `more_xfer` was high.
- R9: `rst`, `sys_reset`, `por_reset` and `halt_mchk` each clear the capture, the return and propagate tags, the gate capture and the pending requests on the next edge.
- R10: While a capture is still held, a further matching poll is propagated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_reset | input | 1 | Channel system reset |
| por_reset | input | 1 | Channel power-on reset |
| halt_mchk | input | 1 | Channel halt or machine check |
| dev_level | input | 4 | Assigned request level |
| irq_req | input | 1 | Strobe: post an interrupt request |
| cs_req | input | 1 | Strobe: post a cycle-steal request |
| burst_req | input | 1 | With cs_req: the request needs a burst |
| more_xfer | input | 1 | Keep the request after service ends |
| poll_id | input | 5 | Poll identifier, kind in bit 4, level in 3:0 |
| poll_tag | input | 1 | Incoming poll tag |
| poll_prime | input | 1 | Permits capture when high |
| svc_gate | input | 1 | Service gate from the channel |
| gate_ret_seen | input | 1 | Transfer logic saw service-gate return |
| req_bus | output | 16 | Request lines, one-hot by level |
| poll_return | output | 1 | Return tag for interrupt or single cycle steal |
| burst_return | output | 1 | Return tag for a burst capture |
| poll_propagate | output | 1 | Poll passed downstream |
| captured | output | 1 | Capture latch |
| svc_capture | output | 1 | Service gate held by this device |

## Verification
A new poll tag rise and a pending capture compete for the decision register in the same cycle. The bench raises a second matching poll while the first capture is still held and expects a propagate, not a second capture. A channel reset can also land in the cycle where a return tag is active. The bench asserts `halt_mchk` mid-poll and checks that the tags and the capture are all low on the next edge. A request strobe one cycle before the tag rise races the decision. The bench expects the lag rule to win and the poll to be propagated.

// File: rtl/poll_cap_pkg.sv
package poll_cap_pkg;
  typedef enum logic {
    KIND_IRQ = 1'b0,
    KIND_CS  = 1'b1
  } poll_kind_e;
endpackage

// File: rtl/pc_req_latch.sv
module pc_req_latch #(
  parameter int LEVEL_W = 4,
  localparam int LINES = 1 << LEVEL_W
) (
  input  logic               clk,
  input  logic               chan_rst,
  input  logic               irq_req,
  input  logic               cs_req,
  input  logic               burst_req,
  input  logic [LEVEL_W-1:0] dev_level,
  input  logic               release_pulse,
  input  logic               release_kind,
  input  logic               more_xfer,
  output logic               irq_q,
  output logic               cs_q,
  output logic               burst_q,
  output logic [LINES-1:0]   req_bus,
  output logic               bus_active
);
  import poll_cap_pkg::*;

  // pending request latches; a new strobe wins over a release in the same cycle
  always_ff @(posedge clk) begin
    if (chan_rst) begin
      irq_q   <= 1'b0;
      cs_q    <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      if (release_pulse && !more_xfer) begin
        if (poll_kind_e'(release_kind) == KIND_CS) begin
          cs_q    <= 1'b0;
          burst_q <= 1'b0;
        end else begin
          irq_q <= 1'b0;
        end
      end
      if (irq_req) irq_q <= 1'b1;
      if (cs_req) begin
        cs_q    <= 1'b1;
        burst_q <= burst_req;
      end
    end
  end

  // registered level decode onto the request lines
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (chan_rst) req_bus[i] <= 1'b0;
      else          req_bus[i] <= (irq_q || cs_q) && (dev_level == LEVEL_W'(i));
    end
  end

  assign bus_active = |req_bus;
endmodule

// File: rtl/pc_decision.sv
module pc_decision #(
  parameter int LEVEL_W = 4,
  localparam int ID_W = LEVEL_W + 1
) (
  input  logic               clk,
  input  logic               chan_rst,
  input  logic               poll_tag,
  input  logic               poll_prime,
  input  logic [ID_W-1:0]    poll_id,
  input  logic [LEVEL_W-1:0] dev_level,
  input  logic               irq_q,
  input  logic               cs_q,
  input  logic               burst_q,
  input  logic               bus_active,
  input  logic               cap_busy,
  output logic               dec_q,
  output logic               dec_burst_q,
  output logic               dec_kind_q
);
  import poll_cap_pkg::*;

  poll_kind_e         id_kind;
  logic [LEVEL_W-1:0] id_level;
  logic               kind_pending;
  logic               take;

  assign id_kind      = poll_kind_e'(poll_id[LEVEL_W]);
  assign id_level     = poll_id[LEVEL_W-1:0];
  assign kind_pending = (id_kind == KIND_CS) ? cs_q : irq_q;
  // bus_active is the registered line: a request not yet on the bus lags
  assign take = poll_prime && !cap_busy && bus_active &&
                (id_level == dev_level) && kind_pending;

  // tracks while the tag is low, frozen while it is high
  always_ff @(posedge clk) begin
    if (chan_rst) begin
      dec_q       <= 1'b0;
      dec_burst_q <= 1'b0;
      dec_kind_q  <= 1'b0;
    end else if (!poll_tag) begin
      dec_q       <= take;
      dec_burst_q <= (id_kind == KIND_CS) && burst_q;
      dec_kind_q  <= id_kind;
    end
  end
endmodule

// File: rtl/pc_capture.sv
module pc_capture (
  input  logic clk,
  input  logic chan_rst,
  input  logic poll_tag,
  input  logic dec_q,
  input  logic dec_burst_q,
  input  logic dec_kind_q,
  input  logic svc_gate,
  input  logic gate_ret_seen,
  output logic poll_return,
  output logic burst_return,
  output logic poll_propagate,
  output logic captured,
  output logic svc_capture,
  output logic release_pulse,
  output logic release_kind
);
  logic tag_q;
  logic tag_rise;

  assign tag_rise      = poll_tag && !tag_q;
  assign release_pulse = svc_capture && gate_ret_seen;

  always_ff @(posedge clk) begin
    if (chan_rst) begin
      tag_q          <= 1'b0;
      poll_return    <= 1'b0;
      burst_return   <= 1'b0;
      poll_propagate <= 1'b0;
      captured       <= 1'b0;
      svc_capture    <= 1'b0;
      release_kind   <= 1'b0;
    end else begin
      tag_q <= poll_tag;
      if (!poll_tag) begin
        poll_return    <= 1'b0;
        burst_return   <= 1'b0;
        poll_propagate <= 1'b0;
      end else if (tag_rise) begin
        if (dec_q) begin
          captured     <= 1'b1;
          release_kind <= dec_kind_q;
          poll_return  <= !dec_burst_q;
          burst_return <= dec_burst_q;
        end else begin
          poll_propagate <= 1'b1;
        end
      end
      if (captured && svc_gate) svc_capture <= 1'b1;
      if (release_pulse) begin
        captured    <= 1'b0;
        svc_capture <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/poll_capture_unit.sv
module poll_capture_unit #(
  parameter int LEVEL_W = 4,
  localparam int LINES = 1 << LEVEL_W,
  localparam int ID_W = LEVEL_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sys_reset,
  input  logic               por_reset,
  input  logic               halt_mchk,
  input  logic [LEVEL_W-1:0] dev_level,
  input  logic               irq_req,
  input  logic               cs_req,
  input  logic               burst_req,
  input  logic               more_xfer,
  input  logic [ID_W-1:0]    poll_id,
  input  logic               poll_tag,
  input  logic               poll_prime,
  input  logic               svc_gate,
  input  logic               gate_ret_seen,
  output logic [LINES-1:0]   req_bus,
  output logic               poll_return,
  output logic               burst_return,
  output logic               poll_propagate,
  output logic               captured,
  output logic               svc_capture
);
  logic chan_rst;
  logic irq_q, cs_q, burst_q, bus_active;
  logic dec_q, dec_burst_q, dec_kind_q;
  logic release_pulse, release_kind;

  assign chan_rst = rst || sys_reset || por_reset || halt_mchk;

  pc_req_latch #(.LEVEL_W(LEVEL_W)) u_req (
    .clk(clk), .chan_rst(chan_rst), .irq_req(irq_req), .cs_req(cs_req),
    .burst_req(burst_req), .dev_level(dev_level),
    .release_pulse(release_pulse), .release_kind(release_kind),
    .more_xfer(more_xfer), .irq_q(irq_q), .cs_q(cs_q), .burst_q(burst_q),
    .req_bus(req_bus), .bus_active(bus_active)
  );

  pc_decision #(.LEVEL_W(LEVEL_W)) u_dec (
    .clk(clk), .chan_rst(chan_rst), .poll_tag(poll_tag),
    .poll_prime(poll_prime), .poll_id(poll_id), .dev_level(dev_level),
    .irq_q(irq_q), .cs_q(cs_q), .burst_q(burst_q), .bus_active(bus_active),
    .cap_busy(captured), .dec_q(dec_q), .dec_burst_q(dec_burst_q),
    .dec_kind_q(dec_kind_q)
  );

  pc_capture u_cap (
    .clk(clk), .chan_rst(chan_rst), .poll_tag(poll_tag), .dec_q(dec_q),
    .dec_burst_q(dec_burst_q), .dec_kind_q(dec_kind_q), .svc_gate(svc_gate),
    .gate_ret_seen(gate_ret_seen), .poll_return(poll_return),
    .burst_return(burst_return), .poll_propagate(poll_propagate),
    .captured(captured), .svc_capture(svc_capture),
    .release_pulse(release_pulse), .release_kind(release_kind)
  );
endmodule

// File: rtl/poll_capture_checker.sv
module poll_capture_checker #(
  parameter int LINES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sys_reset,
  input logic             por_reset,
  input logic             halt_mchk,
  input logic             poll_tag,
  input logic [LINES-1:0] req_bus,
  input logic             poll_return,
  input logic             burst_return,
  input logic             poll_propagate,
  input logic             captured,
  input logic             svc_capture
);
  AST_BUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_bus)); // R1

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
    $countones({poll_return, burst_return, poll_propagate}) <= 1); // R3

  AST_TAG_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    !poll_tag |=> !(poll_return || burst_return || poll_propagate)); // R3

  AST_RETURN_HAS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (poll_return || burst_return) |-> captured); // R4

  AST_GATE_HAS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    svc_capture |-> captured); // R8

  AST_CHAN_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (sys_reset || por_reset || halt_mchk) |=>
      !(captured || svc_capture || poll_return || burst_return || poll_propagate)); // R9
endmodule

bind poll_capture_unit poll_capture_checker #(.LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .sys_reset(sys_reset), .por_reset(por_reset),
  .halt_mchk(halt_mchk), .poll_tag(poll_tag), .req_bus(req_bus),
  .poll_return(poll_return), .burst_return(burst_return),
  .poll_propagate(poll_propagate), .captured(captured),
  .svc_capture(svc_capture)
);

// File: tb/test_poll_capture_unit.sv
module test_poll_capture_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sys_reset = 1'b0, por_reset = 1'b0, halt_mchk = 1'b0;
  logic [3:0]  dev_level = 4'd0;
  logic        irq_req = 1'b0, cs_req = 1'b0, burst_req = 1'b0, more_xfer = 1'b0;
  logic [4:0]  poll_id = 5'd0;
  logic        poll_tag = 1'b0, poll_prime = 1'b0;
  logic        svc_gate = 1'b0, gate_ret_seen = 1'b0;
  logic [15:0] req_bus;
  logic        poll_return, burst_return, poll_propagate, captured, svc_capture;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  poll_capture_unit i_poll_capture_unit (
    .clk(clk), .rst(rst), .sys_reset(sys_reset), .por_reset(por_reset),
    .halt_mchk(halt_mchk), .dev_level(dev_level), .irq_req(irq_req),
    .cs_req(cs_req), .burst_req(burst_req), .more_xfer(more_xfer),
    .poll_id(poll_id), .poll_tag(poll_tag), .poll_prime(poll_prime),
    .svc_gate(svc_gate), .gate_ret_seen(gate_ret_seen), .req_bus(req_bus),
    .poll_return(poll_return), .burst_return(burst_return),
    .poll_propagate(poll_propagate), .captured(captured),
    .svc_capture(svc_capture)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // answer vector {poll_return, burst_return, poll_propagate}
  function automatic logic [31:0] ans();
    return {29'd0, poll_return, burst_return, poll_propagate};
  endfunction

  task automatic do_reset();
    rst = 1'b1; irq_req = 0; cs_req = 0; burst_req = 0; more_xfer = 0;
    poll_tag = 0; poll_prime = 1; svc_gate = 0; gate_ret_seen = 0;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic post(input bit cs, input bit burst);
    if (cs) begin cs_req = 1; burst_req = burst; end else irq_req = 1;
    step(1);
    irq_req = 0; cs_req = 0; burst_req = 0;
    step(2); // bus driven, decision settled
  endtask

  task automatic poll_rise(input logic [4:0] id);
    poll_id = id;
    step(1);
    poll_tag = 1;
    step(1);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R9 reset bus", req_bus, 0);
    check("R9 reset answer", ans(), 0);
    check("R9 reset captured", captured, 0);
  endtask

  task automatic t_irq_capture();
    do_reset();
    dev_level = 4'd5;
    post(1'b0, 1'b0);
    check("R1 bus decode", req_bus, 32'h0020);
    poll_rise({1'b0, 4'd5});
    check("R4 irq poll return", ans(), 3'b100);
    check("R8 captured", captured, 1);
    step(1);
    check("R3 held while tag high", ans(), 3'b100);
    poll_tag = 0;
    step(1);
    check("R3 cleared after tag low", ans(), 0);
    check("R8 capture held", captured, 1);
    svc_gate = 1;
    step(1);
    check("R8 gate capture", svc_capture, 1);
    svc_gate = 0; gate_ret_seen = 1;
    step(1);
    gate_ret_seen = 0;
    check("R8 release", {captured, svc_capture}, 0);
    step(1);
    check("R8 request dropped", req_bus, 0);
  endtask

  task automatic t_more_xfer();
    do_reset();
    dev_level = 4'd9;
    post(1'b1, 1'b0);
    poll_rise({1'b1, 4'd9});
    check("R4 single cycle steal return", ans(), 3'b100);
    poll_tag = 0; svc_gate = 1; more_xfer = 1;
    step(1);
    svc_gate = 0; gate_ret_seen = 1;
    step(1);
    gate_ret_seen = 0;
    step(1);
    check("R8 request kept with more_xfer", req_bus, 32'h0200);
    more_xfer = 0;
  endtask

  task automatic t_burst();
    do_reset();
    dev_level = 4'd15;
    post(1'b1, 1'b1);
    check("R1 top line", req_bus, 32'h8000);
    poll_rise({1'b1, 4'd15});
    check("R4 burst return", ans(), 3'b010);
    poll_tag = 0;
    step(1);
  endtask

  task automatic t_mismatch();
    do_reset();
    dev_level = 4'd3;
    post(1'b0, 1'b0);
    poll_rise({1'b1, 4'd3});
    check("R2 kind mismatch propagates", ans(), 3'b001);
    check("R2 no capture", captured, 0);
    poll_tag = 0;
    poll_rise({1'b0, 4'd4});
    check("R2 level mismatch propagates", ans(), 3'b001);
    poll_tag = 0;
    step(1);
  endtask

  task automatic t_no_prime();
    do_reset();
    dev_level = 4'd2;
    post(1'b0, 1'b0);
    poll_prime = 0;
    poll_rise({1'b0, 4'd2});
    check("R7 propagate without prime", ans(), 3'b001);
    poll_tag = 0;
    step(1);
  endtask

  task automatic t_frozen();
    do_reset();
    dev_level = 4'd7;
    post(1'b0, 1'b0);
    poll_prime = 0;
    poll_id = {1'b0, 4'd7};
    step(1);
    poll_tag = 1; poll_prime = 1;
    step(1);
    check("R5 decision frozen at tag rise", ans(), 3'b001);
    step(2);
    check("R5 still propagating", ans(), 3'b001);
    check("R5 no late capture", captured, 0);
    poll_tag = 0;
    step(1);
  endtask

  task automatic t_lag();
    do_reset();
    dev_level = 4'd1;
    poll_id = {1'b0, 4'd1};
    step(1);
    irq_req = 1;
    step(1);
    irq_req = 0; poll_tag = 1;
    step(1);
    check("R6 lagging request propagates", ans(), 3'b001);
    poll_tag = 0;
    step(1);
  endtask

  task automatic t_busy();
    do_reset();
    dev_level = 4'd6;
    post(1'b0, 1'b0);
    poll_rise({1'b0, 4'd6});
    check("R10 first capture", ans(), 3'b100);
    poll_tag = 0;
    step(1);
    poll_rise({1'b0, 4'd6});
    check("R10 second poll propagated", ans(), 3'b001);
    poll_tag = 0;
    step(1);
  endtask

  task automatic t_chan_reset();
    do_reset();
    dev_level = 4'd4;
    post(1'b0, 1'b0);
    poll_rise({1'b0, 4'd4});
    check("R9 captured before halt", captured, 1);
    halt_mchk = 1;
    step(1);
    halt_mchk = 0;
    check("R9 halt clears", {captured, svc_capture, ans()}, 0);
    poll_tag = 0;
    step(1);
    check("R9 request cleared", req_bus, 0);
    post(1'b0, 1'b0);
    sys_reset = 1;
    step(1);
    sys_reset = 0;
    step(1);
    check("R9 system reset clears bus", req_bus, 0);
    post(1'b0, 1'b0);
    por_reset = 1;
    step(1);
    por_reset = 0;
    step(1);
    check("R9 power-on reset clears bus", req_bus, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_irq_capture();
    t_more_xfer();
    t_burst();
    t_mismatch();
    t_no_prime();
    t_frozen();
    t_lag();
    t_busy();
    t_chan_reset();
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule